// File: doc/BRIEF.md
# Command-Processor Integer ALU

This unit performs the integer work of a small command-processing microcontroller. Each cycle it may accept one 32-bit instruction word together with the two operand values that the register file has already read out. It decodes the variable-length opcode and computes the result for either the immediate-operand form or the two-register form. One clock later it presents the write-back value, the destination index and the repeat flag.

The two register indices that the instruction names are also driven combinationally on the outputs, so that a register file outside the block can look up the operands in the same cycle. A one-bit carry/borrow flag is kept inside the unit. It allows a 64-bit add or subtract to be issued as a low-half instruction followed by a high-half instruction. Register storage, memory access, control-register traffic and branching are handled elsewhere.

Top module: `cp_alu_unit`

## Requirements
- R1: The header is instruction bits 31:26. A header below 0x30 gives opcode = header >> 1, and header bit 0 is the repeat flag, which appears on `wb_rep`. Headers 0x30 and above never produce a write-back.
- R2: Immediate form (any opcode other than 0x13): operand A is the register named by bits 25:21 (`rd_a_idx`), operand B is bits 15:0 zero-extended, and the destination is bits 20:16. `rd_b_idx` always shows bits 20:16.
- R3: Two-register form (opcode 0x13, header 0x26 or 0x27): the function code is bits 4:0 and uses the same numbering as the opcodes. The destination is bits 15:11, A is the register at 25:21 and B is the register at 20:16.
- R4: 0x01 gives A+B, 0x03 gives A-B, 0x05 gives AND, 0x06 gives OR and 0x07 gives XOR, all modulo 2^32. 0x08 gives ~B, and A has no effect on it.
- R5: 0x09 shifts A left, 0x0a shifts A right logically, 0x0b shifts A right arithmetically and 0x0c rotates A left. In every case the amount is B[4:0].
- R6: 0x0d gives A[7:0]*B[7:0], zero-extended. 0x0e gives the unsigned minimum of A and B, and 0x0f gives the unsigned maximum.
- R7: 0x10 compares unsigned. It gives 0 when A equals B, 1 when A is greater than B, and 0xFFFFFFFF when A is less than B.
- R8: 0x11 in the immediate form gives the 16-bit immediate shifted left by bits 25:21. In the two-register form it copies B.
- R9: Function 0x14 exists only in the two-register form. It gives the index of the highest set bit of B, gives 0 when B is 0, and ignores A. Opcode 0x14 in the immediate form does not write back.
- R10: 0x02 gives A+B+flag and 0x04 gives A-B-flag. ADD and ADDHI load the flag with their carry out. SUB and SUBHI load it with their borrow. No other instruction changes the flag, and reset clears it.
- R11: Opcode 0x00, opcodes outside R4–R10, and cycles with `issue` low all leave `wb_valid` low in the following cycle. `wb_data`, `wb_dst` and `wb_rep` keep their previous values.
- R12: The result of an issued legal instruction appears on the outputs in the cycle after `issue`. A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of register `rd_a_idx` |
| src_b | input | 32 | Value of register `rd_b_idx` |
| rd_a_idx | output | 5 | Register index for operand A |
| rd_b_idx | output | 5 | Register index for operand B |
| wb_valid | output | 1 | Write-back strobe |
| wb_dst | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| wb_rep | output | 1 | Decoded repeat flag |

## Verification
The assertions assume that `instr`, `issue`, `src_a` and `src_b` hold known values on every clock edge, starting before reset is released. They also assume that operand values arrive in the same cycle as the instruction that names them. The bench sets every input at time zero and changes the inputs only on falling edges. It feeds the block both arbitrary operand values and arbitrary 32-bit instruction words, which cover every header code, illegal headers included. This keeps all stimulus inside those assumptions while still reaching every decode path.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 16;
    localparam int HDR_W   = 6;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int MUL_W   = 8;

    localparam logic [HDR_W-1:0] LONG_HDR_BASE = 6'h30;

    typedef enum logic [HDR_W-1:0] {
        FN_NONE  = 6'h00,
        FN_ADD   = 6'h01,
        FN_ADDHI = 6'h02,
        FN_SUB   = 6'h03,
        FN_SUBHI = 6'h04,
        FN_AND   = 6'h05,
        FN_OR    = 6'h06,
        FN_XOR   = 6'h07,
        FN_INV   = 6'h08,
        FN_SHL   = 6'h09,
        FN_SHRL  = 6'h0a,
        FN_SHRA  = 6'h0b,
        FN_ROL   = 6'h0c,
        FN_MUL8  = 6'h0d,
        FN_MINU  = 6'h0e,
        FN_MAXU  = 6'h0f,
        FN_CMP   = 6'h10,
        FN_MOV   = 6'h11,
        FN_TWOREG = 6'h13,
        FN_TOPBIT = 6'h14
    } alu_fn_e;

    typedef struct packed {
        logic              legal;
        logic              rep;
        logic              two_reg;
        alu_fn_e           fn;
        logic [IDX_W-1:0]  dst;
        logic [SHAMT_W-1:0] mov_sh;
        logic [IMM_W-1:0]  imm;
    } alu_dec_t;

    typedef struct packed {
        logic              valid;
        logic              rep;
        logic [IDX_W-1:0]  dst;
        logic [XLEN-1:0]   data;
    } alu_wb_t;

    // Function codes that produce a result in the given form.
    function automatic logic code_ok(input logic [HDR_W-1:0] code, input logic two_reg);
        logic ok;
        ok = ((code >= 6'h01) && (code <= 6'h11));
        if (two_reg && (code == 6'h14)) ok = 1'b1;
        return ok;
    endfunction

    function automatic logic [SHAMT_W-1:0] top_bit(input logic [XLEN-1:0] v);
        logic [SHAMT_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (v[i]) idx = SHAMT_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/cpalu_decode.sv
module cpalu_decode
    import cpalu_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output alu_dec_t        dec
);
    logic [HDR_W-1:0] hdr;
    logic [HDR_W-1:0] major;
    logic [HDR_W-1:0] code;
    logic             two_reg;

    always_comb begin
        hdr = instr[XLEN-1 -: HDR_W];
        if (hdr < LONG_HDR_BASE) begin
            major   = {1'b0, hdr[HDR_W-1:1]};
            dec.rep = hdr[0];
        end else begin
            major   = hdr;
            dec.rep = 1'b0;
        end
        two_reg = (major == FN_TWOREG);
        code    = two_reg ? {1'b0, instr[IDX_W-1:0]} : major;

        dec.two_reg = two_reg;
        dec.legal   = code_ok(code, two_reg);
        dec.fn      = dec.legal ? alu_fn_e'(code) : FN_NONE;
        dec.dst     = two_reg ? instr[15:11] : instr[20:16];
        dec.mov_sh  = instr[25:21];
        dec.imm     = instr[IMM_W-1:0];
    end
endmodule

// File: rtl/cpalu_exec.sv
module cpalu_exec
    import cpalu_pkg::*;
(
    input  alu_fn_e              fn,
    input  logic                 two_reg,
    input  logic [XLEN-1:0]      opa,
    input  logic [XLEN-1:0]      opb,
    input  logic [IMM_W-1:0]     imm,
    input  logic [SHAMT_W-1:0]   mov_sh,
    input  logic                 flag_in,
    output logic [XLEN-1:0]      result,
    output logic                 flag_we,
    output logic                 flag_out
);
    logic [XLEN:0]        sum_w;
    logic [XLEN:0]        dif_w;
    logic                 cin;
    logic [SHAMT_W-1:0]   sh;
    logic [SHAMT_W:0]     rsh;
    logic [2*MUL_W-1:0]   prod;
    logic [XLEN-1:0]      imm_x;

    always_comb begin
        cin   = ((fn == FN_ADDHI) || (fn == FN_SUBHI)) ? flag_in : 1'b0;
        sum_w = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
        dif_w = {1'b0, opa} - {1'b0, opb} - {{XLEN{1'b0}}, cin};
        sh    = opb[SHAMT_W-1:0];
        rsh   = (SHAMT_W+1)'(XLEN) - {1'b0, sh};
        prod  = opa[MUL_W-1:0] * opb[MUL_W-1:0];
        imm_x = {{(XLEN-IMM_W){1'b0}}, imm};

        flag_we  = 1'b0;
        flag_out = 1'b0;
        unique case (fn)
            FN_ADD, FN_ADDHI: begin
                result   = sum_w[XLEN-1:0];
                flag_we  = 1'b1;
                flag_out = sum_w[XLEN];
            end
            FN_SUB, FN_SUBHI: begin
                result   = dif_w[XLEN-1:0];
                flag_we  = 1'b1;
                flag_out = dif_w[XLEN];
            end
            FN_AND:  result = opa & opb;
            FN_OR:   result = opa | opb;
            FN_XOR:  result = opa ^ opb;
            FN_INV:  result = ~opb;
            FN_SHL:  result = opa << sh;
            FN_SHRL: result = opa >> sh;
            FN_SHRA: result = $unsigned($signed(opa) >>> sh);
            FN_ROL:  result = (opa << sh) | (opa >> rsh);
            FN_MUL8: result = {{(XLEN-2*MUL_W){1'b0}}, prod};
            FN_MINU: result = (opa < opb) ? opa : opb;
            FN_MAXU: result = (opa > opb) ? opa : opb;
            FN_CMP: begin
                if (opa == opb)     result = '0;
                else if (opa > opb) result = XLEN'(1);
                else                result = '1;
            end
            FN_MOV:    result = two_reg ? opb : (imm_x << mov_sh);
            FN_TOPBIT: result = {{(XLEN-SHAMT_W){1'b0}}, top_bit(opb)};
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/cp_alu_unit.sv
module cp_alu_unit
    import cpalu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [XLEN-1:0]     instr,
    input  logic [XLEN-1:0]     src_a,
    input  logic [XLEN-1:0]     src_b,
    output logic [IDX_W-1:0]    rd_a_idx,
    output logic [IDX_W-1:0]    rd_b_idx,
    output logic                wb_valid,
    output logic [IDX_W-1:0]    wb_dst,
    output logic [XLEN-1:0]     wb_data,
    output logic                wb_rep
);
    alu_dec_t        dec;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] res;
    logic            fl_we;
    logic            fl_nxt;
    logic            flag_q;
    alu_wb_t         wb_q;

    assign rd_a_idx = instr[25:21];
    assign rd_b_idx = instr[20:16];

    cpalu_decode i_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign opb = dec.two_reg ? src_b : {{(XLEN-IMM_W){1'b0}}, dec.imm};

    cpalu_exec i_exec (
        .fn       (dec.fn),
        .two_reg  (dec.two_reg),
        .opa      (src_a),
        .opb      (opb),
        .imm      (dec.imm),
        .mov_sh   (dec.mov_sh),
        .flag_in  (flag_q),
        .result   (res),
        .flag_we  (fl_we),
        .flag_out (fl_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (issue && dec.legal && fl_we) begin
            flag_q <= fl_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q.valid <= issue && dec.legal;
            if (issue && dec.legal) begin
                wb_q.rep  <= dec.rep;
                wb_q.dst  <= dec.dst;
                wb_q.data <= res;
            end
        end
    end

    assign wb_valid = wb_q.valid;
    assign wb_dst   = wb_q.dst;
    assign wb_data  = wb_q.data;
    assign wb_rep   = wb_q.rep;
endmodule

// File: rtl/cpalu_checker.sv
module cpalu_checker
    import cpalu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             issue,
    input logic [XLEN-1:0]  instr,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_dst,
    input logic [XLEN-1:0]  wb_data,
    input logic             wb_rep
);
    // R12: a write-back is always caused by an issue one cycle earlier
    a_r12_valid_after_issue: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(issue));

    // R1: long headers never write back
    a_r1_long_hdr_silent: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:30] == 2'b11) |=> !wb_valid);

    // R1: repeat flag is header bit 0 for short headers
    a_r1_rep_bit: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:30] != 2'b11) |=> (!wb_valid || wb_rep == $past(instr[26])));

    // R4: immediate inversion ignores operand A
    a_r4_inv_imm: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:27] == 5'h08) |=>
            (wb_valid && wb_data == ~{16'h0, $past(instr[15:0])}));

    // R6: byte product fits in 16 bits
    a_r6_mul8_narrow: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:27] == 5'h0d) |=> (wb_valid && wb_data[31:16] == 16'h0));

    // R9: top-bit index is a valid bit position
    a_r9_topbit_range: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:27] == 5'h13 && instr[4:0] == 5'h14) |=>
            (wb_valid && wb_data < 32'd32));

    // R11: idle cycles keep outputs
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (!wb_valid && $stable(wb_data) && $stable(wb_dst) && $stable(wb_rep)));

    // R11: opcode zero is silent
    a_r11_nop_silent: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[31:27] == 5'h00) |=> !wb_valid);
endmodule

bind cp_alu_unit cpalu_checker i_cpalu_checker (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .instr    (instr),
    .wb_valid (wb_valid),
    .wb_dst   (wb_dst),
    .wb_data  (wb_data),
    .wb_rep   (wb_rep)
);

// File: tb/test_cp_alu_unit.sv
module test_cp_alu_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] src_a = 32'h0;
    logic [31:0] src_b = 32'h0;
    logic [4:0]  rd_a_idx, rd_b_idx, wb_dst;
    logic        wb_valid, wb_rep;
    logic [31:0] wb_data;

    int checks = 0;
    int errors = 0;

    bit          m_flag = 0;
    bit          e_valid = 0;
    bit          e_rep = 0;
    logic [4:0]  e_dst = 0;
    logic [31:0] e_data = 0;
    string       e_tag = "R12";

    always #5 clk = ~clk;

    cp_alu_unit i_cp_alu_unit (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr),
        .src_a(src_a), .src_b(src_b), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data), .wb_rep(wb_rep)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_imm(input int op, input bit rp, input int src,
                                           input int dst, input int imm);
        return {5'(op), rp, 5'(src), 5'(dst), 16'(imm)};
    endfunction

    function automatic logic [31:0] mk_reg(input int fn, input int dst, input int s1, input int s2);
        return {5'h13, 1'b0, 5'(s1), 5'(s2), 5'(dst), 6'h0, 5'(fn)};
    endfunction

    // Behavioural reference of one issued instruction; updates m_flag.
    task automatic model(input logic [31:0] ins, input logic [31:0] ra, input logic [31:0] rb,
                         output bit ok, output logic [31:0] res, output logic [4:0] dst,
                         output bit rp, output string tag);
        int hdr, op, fn;
        bit two;
        longint unsigned a, b, t;
        hdr = int'(ins[31:26]);
        ok = 1; res = 0; rp = 0; tag = "R11";
        if (hdr >= 48) begin
            ok = 0; tag = "R1"; op = hdr;
        end else begin
            op = hdr / 2; rp = bit'(hdr % 2);
        end
        two = (op == 19);
        fn  = two ? int'(ins[4:0]) : op;
        dst = two ? ins[15:11] : ins[20:16];
        a = longint'(ra);
        b = two ? longint'(rb) : longint'(ins[15:0]);
        if (hdr < 48) begin
            case (fn)
                1: begin t = a + b; res = t[31:0]; m_flag = t[32]; tag = "R4"; end
                3: begin res = 32'(a - b); m_flag = (a < b); tag = "R4"; end
                2: begin t = a + b + longint'(m_flag); res = t[31:0]; m_flag = t[32]; tag = "R10"; end
                4: begin t = b + longint'(m_flag); res = 32'(a - t); m_flag = (a < t); tag = "R10"; end
                5: begin res = 32'(a & b); tag = "R4"; end
                6: begin res = 32'(a | b); tag = "R4"; end
                7: begin res = 32'(a ^ b); tag = "R4"; end
                8: begin res = ~32'(b); tag = "R4"; end
                9: begin res = 32'(a << (b % 32)); tag = "R5"; end
                10: begin res = 32'(a >> (b % 32)); tag = "R5"; end
                11: begin
                    t = a; for (int i = 0; i < int'(b % 32); i++) t = (t >> 1) | (t & 64'h8000_0000);
                    res = t[31:0]; tag = "R5";
                end
                12: begin t = (a << (b % 32)); res = t[31:0] | t[63:32]; tag = "R5"; end
                13: begin res = 32'((a % 256) * (b % 256)); tag = "R6"; end
                14: begin res = 32'((a < b) ? a : b); tag = "R6"; end
                15: begin res = 32'((a > b) ? a : b); tag = "R6"; end
                16: begin res = (a == b) ? 0 : ((a > b) ? 1 : 32'hFFFF_FFFF); tag = "R7"; end
                17: begin res = two ? 32'(b) : 32'(longint'(ins[15:0]) << ins[25:21]); tag = "R8"; end
                20: begin
                    tag = "R9"; ok = two;
                    for (int i = 0; i < 32; i++) if (b[i]) res = 32'(i);
                end
                default: begin ok = 0; tag = "R11"; end
            endcase
        end
        if (!ok) res = 0;
    endtask

    task automatic step(input bit iss, input logic [31:0] ins,
                        input logic [31:0] ra, input logic [31:0] rb);
        bit ok, rp;
        logic [31:0] res;
        logic [4:0] dst;
        string tag;
        issue = iss; instr = ins; src_a = ra; src_b = rb;
        #1;
        check("R2", "rd_a_idx", 32'(rd_a_idx), 32'(ins[25:21]));
        check("R3", "rd_b_idx", 32'(rd_b_idx), 32'(ins[20:16]));
        if (iss) begin
            model(ins, ra, rb, ok, res, dst, rp, tag);
            e_valid = ok;
            e_tag = tag;
            if (ok) begin e_data = res; e_dst = dst; e_rep = rp; end
        end else begin
            e_valid = 0; e_tag = "R11";
        end
        @(negedge clk);
        check(e_tag, "wb_valid", 32'(wb_valid), 32'(e_valid));
        check(e_tag, "wb_data",  wb_data, e_data);
        check(e_tag, "wb_dst",   32'(wb_dst), 32'(e_dst));
        check(e_tag == "R11" ? "R11" : "R1", "wb_rep", 32'(wb_rep), 32'(e_rep));
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "reset wb_valid", 32'(wb_valid), 0);
        check("R12", "reset wb_data", wb_data, 0);
        check("R12", "reset wb_dst", 32'(wb_dst), 0);
        check("R12", "reset wb_rep", 32'(wb_rep), 0);
        rst = 0;
        // R4 basic arithmetic and logic, immediate and register forms
        step(1, mk_imm(1, 0, 3, 7, 16'h0010), 32'h0000_0005, 32'h0);
        step(1, mk_reg(3, 9, 1, 2), 32'h0000_0005, 32'h0000_0009);
        step(1, mk_reg(7, 4, 1, 2), 32'hF0F0_F0F0, 32'h0FF0_0FF0);
        step(1, mk_imm(8, 0, 6, 2, 16'h00FF), 32'hDEAD_BEEF, 32'h0);
        // R10 64-bit add chain; AND between must not touch the flag
        step(1, mk_reg(1, 2, 1, 2), 32'hFFFF_FFFF, 32'h0000_0001);
        step(1, mk_imm(5, 0, 1, 2, 16'hFFFF), 32'h1234_5678, 32'h0);
        step(1, mk_reg(2, 3, 1, 2), 32'h0000_0005, 32'h0000_0000);
        // R10 borrow chain
        step(1, mk_reg(3, 2, 1, 2), 32'h0, 32'h1);
        step(1, mk_imm(4, 0, 1, 3, 16'h0002), 32'h0000_000A, 32'h0);
        step(1, mk_imm(2, 0, 1, 3, 16'h0000), 32'h0000_0000, 32'h0);
        // R5 shifts and rotate
        step(1, mk_reg(11, 1, 1, 2), 32'h8000_0010, 32'h0000_0004);
        step(1, mk_reg(12, 1, 1, 2), 32'h8000_0001, 32'h0000_0001);
        step(1, mk_reg(12, 1, 1, 2), 32'h8000_0001, 32'h0000_0000);
        step(1, mk_imm(10, 1, 1, 1, 16'h001F), 32'h8000_0000, 32'h0);
        // R6 multiply, min and max
        step(1, mk_reg(13, 5, 1, 2), 32'h0000_01FF, 32'h0000_0302);
        step(1, mk_reg(14, 5, 1, 2), 32'h8000_0000, 32'h0000_0001);
        step(1, mk_reg(15, 5, 1, 2), 32'h8000_0000, 32'h0000_0001);
        // R7 compare: equal, greater, less
        step(1, mk_imm(16, 0, 1, 6, 16'h0042), 32'h0000_0042, 32'h0);
        step(1, mk_imm(16, 0, 1, 6, 16'h0042), 32'h0000_0043, 32'h0);
        step(1, mk_imm(16, 0, 1, 6, 16'h0042), 32'h0000_0041, 32'h0);
        // R8 move immediate shifted, and register copy
        step(1, mk_imm(17, 0, 16, 8, 16'h1234), 32'h0, 32'h0);
        step(1, mk_reg(17, 8, 1, 2), 32'h0, 32'hCAFE_F00D);
        // R9 top-bit finder
        step(1, mk_reg(20, 9, 1, 2), 32'hFFFF_FFFF, 32'h0);
        step(1, mk_reg(20, 9, 1, 2), 32'h0, 32'h1);
        step(1, mk_reg(20, 9, 1, 2), 32'h0, 32'h8000_0000);
        step(1, mk_imm(20, 0, 1, 9, 16'h0001), 32'h0, 32'h0);
        // R11 nop, unknown, idle; R1 long header
        step(1, mk_imm(0, 1, 1, 9, 16'h0001), 32'h0, 32'h0);
        step(1, mk_imm(18, 0, 1, 9, 16'h0001), 32'h0, 32'h0);
        step(0, mk_imm(1, 0, 1, 9, 16'h0001), 32'h5, 32'h0);
        step(1, {6'h34, 26'h0}, 32'h0, 32'h0);
        step(1, {6'h35, 26'h3FF_FFFF}, 32'h1, 32'h1);
        step(1, mk_reg(1, 30, 1, 2), 32'h1, 32'h1);
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, $urandom, $urandom, $urandom);
        end
        // R12 reset clears outputs
        rst = 1;
        @(negedge clk);
        check("R12", "reset again", 32'(wb_valid), 0);
        check("R12", "reset again data", wb_data, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule